// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block tracks the coherence state of every line of a small direct-mapped private cache that sits on a shared bus. The bus is atomic: a granted command completes within its grant cycle. Each line is Invalid, Shared, Exclusive-clean or Modified. The processor side accepts read, write and evict requests. It completes them at once when the local state permits. Otherwise it raises a bus request carrying a read, read-for-ownership, upgrade or write-back command. The processor waits until the grant cycle, in which the new state is written.

The snoop side watches the commands of the other caches. It answers with a shared indication and a dirty indication, and it demotes or invalidates the local copy. A fill picks Exclusive-clean or Shared from the wired-OR shared line sampled in the grant cycle. A write to an Exclusive-clean line becomes Modified silently. A write to a Shared line sends an upgrade that moves no data. The data array, the arbiter and memory are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped read (command 1) to any address gets no shared or dirty response, and a processor read issues a bus read.
- R2: A read miss raises bus_req with command 1 and bus_addr equal to the request address. proc_done stays low until the cycle in which bus_grant is high, and rises in that cycle.
- R3: A fill takes Exclusive-clean when bus_shared_in is low in the grant cycle, and Shared when it is high. A later write to an Exclusive-clean line needs no bus. A later write to a Shared line issues command 3.
- R4: A read that hits a valid line, and a write that hits an Exclusive-clean or Modified line, complete in the request cycle with bus_req low. A write to an Exclusive-clean line leaves it Modified.
- R5: A write to an absent or Invalid line issues command 2 (read for ownership) and leaves the line Modified.
- R6: A write to a Shared line issues command 3 (upgrade) and leaves the line Modified. If the line is invalidated while the write waits, the write issues command 2 instead.
- R7: A snooped read (command 1) that hits a valid line asserts snp_shared. A hit in Modified also asserts snp_dirty. Exclusive-clean and Modified lines then move to Shared.
- R8: A snooped read for ownership (2) or upgrade (3) that hits a valid line invalidates it, and asserts snp_dirty if the line was Modified.
- R9: A snoop that misses (Invalid line or other tag), and any snooped write-back (command 4), gives no response and changes no state.
- R10: Evicting a Modified line issues command 4 at its address and leaves the line Invalid. Evicting a clean line completes at once with no bus traffic and leaves it Invalid. Evicting an address whose tag does not match the stored line has no effect.
- R11: A read or write miss whose index holds a Modified line of another tag first writes that line back (command 4 at its address) and then issues the fill command.
- R12: In any cycle with snp_valid high the processor side stays stalled: proc_done and bus_req are low.

Processor op encoding: 0 read, 1 write, 2 evict, 3 treated as read. Bus command encoding: 0 none, 1 read, 2 read for ownership, 3 upgrade, 4 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_valid | input | 1 | Processor request held until proc_done |
| proc_op | input | 2 | Request kind |
| proc_addr | input | ADDR_W | Line address of request |
| proc_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 3 | Command of the request (0 when idle) |
| bus_addr | output | ADDR_W | Line address of the command |
| bus_grant | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 3 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy (snooped read) |
| snp_dirty | output | 1 | This cache holds the line Modified and supplies it |

## Verification
The bench builds the block with ADDR_W=8 and IDX_W=2. That gives four lines with a six-bit tag, so addresses such as 0x23 and 0x63 collide on one index. Conflict write-backs, mismatched-tag evicts and snoop misses on a valid line therefore come up in both directed and random traffic. Random traffic over sixteen addresses, with varied grant delays and shared-line values, drives every line through each state transition.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_UPGR = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_RSV = 2'd3
    } proc_op_e;

    function automatic line_st_e fill_state(input logic shared);
        return shared ? ST_S : ST_E;
    endfunction

    function automatic line_st_e snoop_next(input line_st_e st, input bus_cmd_e cmd);
        line_st_e n;
        n = st;
        case (cmd)
            CMD_RD:            if (st == ST_E || st == ST_M) n = ST_S;
            CMD_RDX, CMD_UPGR: n = ST_I;
            default:           n = st;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] pa_idx,
    output line_st_e         pa_st,
    output logic [TAG_W-1:0] pa_tag,
    input  logic [IDX_W-1:0] sb_idx,
    output line_st_e         sb_st,
    output logic [TAG_W-1:0] sb_tag,
    input  logic             pw_en,
    input  line_st_e         pw_st,
    input  logic [TAG_W-1:0] pw_tag,
    input  logic             sw_en,
    input  line_st_e         sw_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= ST_I;
            end else if (sw_en && sb_idx == IDX_W'(i)) begin
                st_q[i] <= sw_st;
            end else if (pw_en && pa_idx == IDX_W'(i)) begin
                st_q[i]  <= pw_st;
                tag_q[i] <= pw_tag;
            end
        end
    end

    assign pa_st  = st_q[pa_idx];
    assign pa_tag = tag_q[pa_idx];
    assign sb_st  = st_q[sb_idx];
    assign sb_tag = tag_q[sb_idx];

    // R12
    one_writer_chk: assert property (@(posedge clk) disable iff (rst)
        !(pw_en && sw_en));

endmodule

// File: rtl/mesi_snoop_side.sv
module mesi_snoop_side
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] tag,
    output logic             shared,
    output logic             dirty,
    output logic             we,
    output line_st_e         nst
);
    logic hit;

    always_comb begin
        hit    = snp_valid && (st != ST_I) && (tag == snp_tag);
        shared = 1'b0;
        dirty  = 1'b0;
        nst    = st;
        we     = 1'b0;
        if (hit) begin
            case (snp_cmd)
                CMD_RD: begin
                    shared = 1'b1;
                    dirty  = (st == ST_M);
                end
                CMD_RDX, CMD_UPGR: dirty = (st == ST_M);
                default: ;
            endcase
            nst = snoop_next(st, snp_cmd);
            we  = (nst != st);
        end
    end

    // R7
    dirty_read_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_cmd == CMD_RD && dirty) |-> shared);

endmodule

// File: rtl/mesi_proc_side.sv
module mesi_proc_side
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  proc_op_e         op,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] tag,
    input  logic             snp_busy,
    input  logic             grant,
    input  logic             shared_in,
    output logic             done,
    output logic             req,
    output bus_cmd_e         cmd,
    output logic             victim,
    output logic             we,
    output line_st_e         nst,
    output logic [TAG_W-1:0] ntag
);
    logic hit, victim_m;

    always_comb begin
        hit      = (st != ST_I) && (tag == req_tag);
        victim_m = (st == ST_M) && !hit;
        done     = 1'b0;
        req      = 1'b0;
        cmd      = CMD_NONE;
        victim   = 1'b0;
        we       = 1'b0;
        nst      = st;
        ntag     = tag;
        if (req_valid && !snp_busy) begin
            case (op)
                OP_WR: begin
                    if (hit && (st == ST_E || st == ST_M)) begin
                        done = 1'b1;
                        we   = 1'b1;
                        nst  = ST_M;
                    end else if (victim_m) begin
                        req    = 1'b1;
                        cmd    = CMD_WB;
                        victim = 1'b1;
                    end else begin
                        req = 1'b1;
                        cmd = hit ? CMD_UPGR : CMD_RDX;
                    end
                end
                OP_EV: begin
                    if (hit && st == ST_M) begin
                        req = 1'b1;
                        cmd = CMD_WB;
                    end else begin
                        done = 1'b1;
                        if (hit) begin
                            we  = 1'b1;
                            nst = ST_I;
                        end
                    end
                end
                default: begin
                    if (hit) begin
                        done = 1'b1;
                    end else if (victim_m) begin
                        req    = 1'b1;
                        cmd    = CMD_WB;
                        victim = 1'b1;
                    end else begin
                        req = 1'b1;
                        cmd = CMD_RD;
                    end
                end
            endcase
            if (req && grant) begin
                we = 1'b1;
                if (cmd == CMD_WB) begin
                    nst  = ST_I;
                    done = (op == OP_EV);
                end else begin
                    done = 1'b1;
                    ntag = req_tag;
                    nst  = (op == OP_WR) ? ST_M : fill_state(shared_in);
                end
            end
        end
    end

    // R6
    upgr_from_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_UPGR) |-> (st == ST_S));

    // R4
    silent_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !grant) |-> !req);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_valid,
    input  logic [1:0]        proc_op,
    input  logic [ADDR_W-1:0] proc_addr,
    output logic              proc_done,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] p_idx, s_idx;
    logic [TAG_W-1:0] p_tag, s_tag, pa_tag, sb_tag, p_ntag;
    line_st_e         pa_st, sb_st, p_nst, s_nst;
    logic             p_we, s_we, p_victim;
    bus_cmd_e         p_cmd;

    assign p_idx = proc_addr[IDX_W-1:0];
    assign p_tag = proc_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .pa_idx(p_idx), .pa_st(pa_st), .pa_tag(pa_tag),
        .sb_idx(s_idx), .sb_st(sb_st), .sb_tag(sb_tag),
        .pw_en(p_we), .pw_st(p_nst), .pw_tag(p_ntag),
        .sw_en(s_we), .sw_st(s_nst)
    );

    mesi_snoop_side #(.TAG_W(TAG_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(s_tag),
        .st(sb_st), .tag(sb_tag),
        .shared(snp_shared), .dirty(snp_dirty), .we(s_we), .nst(s_nst)
    );

    mesi_proc_side #(.TAG_W(TAG_W)) u_proc (
        .clk(clk), .rst(rst),
        .req_valid(proc_valid), .op(proc_op_e'(proc_op)), .req_tag(p_tag),
        .st(pa_st), .tag(pa_tag),
        .snp_busy(snp_valid), .grant(bus_grant), .shared_in(bus_shared_in),
        .done(proc_done), .req(bus_req), .cmd(p_cmd), .victim(p_victim),
        .we(p_we), .nst(p_nst), .ntag(p_ntag)
    );

    assign bus_cmd  = p_cmd;
    assign bus_addr = p_victim ? {pa_tag, p_idx} : proc_addr;

    // R2
    stall_until_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_grant) |-> !proc_done);

    // R12
    snoop_stalls_proc_chk: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> (!proc_done && !bus_req));

    // R10
    wb_only_requested_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 3'd4) |-> bus_req);

    // R9
    wb_snoop_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 3'd4) |-> (!snp_shared && !snp_dirty));

endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int LINES = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          proc_valid = 1'b0;
    logic [1:0]    proc_op = 2'd0;
    logic [AW-1:0] proc_addr = '0;
    logic          proc_done, bus_req;
    logic [2:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_grant = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [2:0]    snp_cmd = 3'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_dirty;

    mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst),
        .proc_valid(proc_valid), .proc_op(proc_op), .proc_addr(proc_addr),
        .proc_done(proc_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    string cur_tag = "";

    // reference model: 0 Invalid, 1 Shared, 2 Exclusive-clean, 3 Modified
    int m_st  [LINES];
    int m_tag [LINES];
    int e_done, e_req, e_cmd, e_addr, e_sh, e_dt;
    int u_we, u_idx, u_st, u_tag;
    int last_done;

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    function automatic void model_eval();
        int idx, tg, st, ct;
        bit hit, vm;
        e_done = 0; e_req = 0; e_cmd = 0; e_addr = 0; e_sh = 0; e_dt = 0;
        u_we = 0; u_idx = 0; u_st = 0; u_tag = 0;
        if (snp_valid) begin
            idx = int'(snp_addr) % LINES;
            tg  = int'(snp_addr) / LINES;
            st  = m_st[idx];
            hit = (st != 0) && (m_tag[idx] == tg);
            u_idx = idx; u_tag = m_tag[idx];
            if (hit) begin
                if (snp_cmd == 3'd1) begin
                    e_sh = 1;
                    e_dt = (st == 3) ? 1 : 0;
                    if (st >= 2) begin u_we = 1; u_st = 1; end
                end else if (snp_cmd == 3'd2 || snp_cmd == 3'd3) begin
                    e_dt = (st == 3) ? 1 : 0;
                    u_we = 1; u_st = 0;
                end
            end
        end else if (proc_valid) begin
            idx = int'(proc_addr) % LINES;
            tg  = int'(proc_addr) / LINES;
            st  = m_st[idx];
            ct  = m_tag[idx];
            hit = (st != 0) && (ct == tg);
            vm  = (st == 3) && !hit;
            u_idx = idx; u_tag = ct; u_st = st;
            e_addr = int'(proc_addr);
            if (proc_op == 2'd1) begin
                if (hit && st >= 2) begin e_done = 1; u_we = 1; u_st = 3; end
                else if (vm) begin e_req = 1; e_cmd = 4; e_addr = ct * LINES + idx; end
                else begin e_req = 1; e_cmd = hit ? 3 : 2; end
            end else if (proc_op == 2'd2) begin
                if (hit && st == 3) begin e_req = 1; e_cmd = 4; end
                else begin e_done = 1; if (hit) begin u_we = 1; u_st = 0; end end
            end else begin
                if (hit) e_done = 1;
                else if (vm) begin e_req = 1; e_cmd = 4; e_addr = ct * LINES + idx; end
                else begin e_req = 1; e_cmd = 1; end
            end
            if (e_req != 0 && bus_grant) begin
                u_we = 1;
                if (e_cmd == 4) begin
                    u_st = 0; u_tag = ct;
                    e_done = (proc_op == 2'd2) ? 1 : 0;
                end else begin
                    e_done = 1; u_tag = tg;
                    u_st = (proc_op == 2'd1) ? 3 : (bus_shared_in ? 1 : 2);
                end
            end
        end
    endfunction

    task automatic compare();
        string td, tc, ts;
        td = snp_valid ? "R12" : (e_req != 0 ? "R2" : "R4");
        case (e_cmd)
            1: tc = "R2";
            2: tc = "R5";
            3: tc = "R6";
            4: tc = (proc_op == 2'd2) ? "R10" : "R11";
            default: tc = "R4";
        endcase
        if (snp_valid && snp_cmd == 3'd1 && e_sh != 0) ts = "R7";
        else if (snp_valid && (snp_cmd == 3'd2 || snp_cmd == 3'd3) && u_we != 0) ts = "R8";
        else ts = "R9";
        if (cur_tag != "") begin td = cur_tag; tc = cur_tag; ts = cur_tag; end
        chk({td, " proc_done"}, int'(proc_done), e_done);
        chk({tc, " bus_req"}, int'(bus_req), e_req);
        chk({tc, " bus_cmd"}, int'(bus_cmd), e_cmd);
        if (e_req != 0) chk({tc, " bus_addr"}, int'(bus_addr), e_addr);
        chk({ts, " snp_shared"}, int'(snp_shared), e_sh);
        chk({ts, " snp_dirty"}, int'(snp_dirty), e_dt);
    endtask

    task automatic step();
        #1;
        model_eval();
        compare();
        last_done = e_done;
        @(posedge clk);
        if (u_we != 0) begin
            m_st[u_idx]  = u_st;
            m_tag[u_idx] = u_tag;
        end
        @(negedge clk);
    endtask

    task automatic do_op(input int op, input int addr, input int sh, input int dly, input bit collide);
        int cnt;
        proc_valid = 1'b1;
        proc_op = 2'(op);
        proc_addr = AW'(addr);
        bus_shared_in = sh[0];
        cnt = 0;
        last_done = 0;
        while (last_done == 0 && cnt < 60) begin
            if (collide && cnt == 0) begin
                snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = AW'(addr);
            end else begin
                snp_valid = 1'b0;
            end
            bus_grant = 1'b0;
            #1;
            model_eval();
            if (e_req != 0 && cnt >= dly) bus_grant = 1'b1;
            step();
            cnt++;
        end
        proc_valid = 1'b0; bus_grant = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic do_snp(input int cmd, input int addr);
        snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_addr = AW'(addr);
        step();
        snp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, every index answers nothing
        for (int i = 0; i < LINES; i++) begin
            snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = AW'(i + 8);
            #1;
            chk("R1 snp_shared after reset", int'(snp_shared), 0);
            chk("R1 snp_dirty after reset", int'(snp_dirty), 0);
            @(negedge clk);
        end
        snp_valid = 1'b0;
        #1;
        chk("R1 idle proc_done", int'(proc_done), 0);
        chk("R1 idle bus_req", int'(bus_req), 0);
        @(negedge clk);
        cur_tag = "R1";
        do_op(0, 'h09, 0, 0, 0);
        cur_tag = "";

        // read miss, no sharers, grant after 2 waits -> E
        do_op(0, 'h05, 0, 2, 0);
        cur_tag = "R3";
        do_op(1, 'h05, 0, 0, 0);      // silent E->M
        cur_tag = "";
        do_snp(1, 'h05);              // R7 dirty, demote to S
        do_op(1, 'h05, 0, 1, 0);      // R6 upgrade
        do_snp(2, 'h05);              // R8 invalidate with dirty
        do_snp(1, 'h05);              // now no response

        // fill with sharers -> S, write upgrades
        do_op(0, 'h12, 1, 0, 0);
        cur_tag = "R3";
        do_op(1, 'h12, 0, 0, 0);
        cur_tag = "";
        do_snp(3, 'h12);              // R8 upgrade from other, dirty

        // write miss, hit, conflict miss with dirty victim
        do_op(1, 'h23, 0, 1, 0);      // R5
        do_op(0, 'h23, 0, 0, 0);      // R4
        cur_tag = "R11";
        do_op(0, 'h63, 0, 1, 0);
        cur_tag = "";

        // evicts
        do_op(2, 'h63, 0, 0, 0);      // clean evict
        do_snp(1, 'h63);              // R10 line gone
        do_op(1, 'h40, 0, 0, 0);
        do_op(2, 'h80, 0, 0, 0);      // tag mismatch, no effect
        do_snp(1, 'h40);              // still Modified -> dirty, now S
        do_op(1, 'h40, 0, 0, 0);      // back to M via upgrade
        do_op(2, 'h40, 0, 2, 0);      // R10 write-back

        // snoop misses and snooped write-back
        do_op(1, 'h44, 0, 0, 0);
        do_snp(2, 'h84);              // R9 other tag
        do_snp(4, 'h44);              // R9 write-back ignored
        do_snp(1, 'h47);              // R9 invalid line
        do_snp(1, 'h44);              // still dirty

        // R12: snoop in the request cycle stalls the processor
        do_op(0, 'h44, 0, 0, 1);
        do_op(1, 'h44, 1, 0, 1);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int a, k;
            a = (($urandom % 4) << 6) | ($urandom % 4);
            k = $urandom % 8;
            if (k < 3) do_snp(1 + ($urandom % 4), a);
            else do_op($urandom % 4, a, $urandom % 2, $urandom % 3, bit'($urandom % 4 == 0));
        end

        summary();
        $finish;
    end
endmodule